// File: doc/BRIEF.md
# Variable-Block Carry Select Adder

This block adds two 32-bit operands and a carry-in and returns a 32-bit sum with a carry-out. It is purely combinational. The operand width is cut into six slices whose widths grow toward the most significant end.

The least significant slice is a plain ripple chain fed by the adder carry-in. Every higher slice holds two ripple chains that run side by side. One chain assumes the slice receives a carry of 0, and the other assumes a carry of 1. When the true carry reaches the slice, it steers 2:1 multiplexers that pick the slice's sum bits and its carry-out.

The slice widths are chosen so that the internal ripple of each slice finishes at about the time its select carry arrives. The widths form a parameter, and the operand width is derived from them. The block has no data flow to pace, so its ports carry no valid/ready handshake.

Top module: `csa_vblock_adder`

## Requirements
- R1: For any inputs, {cout, sum} equals the 33-bit value of a + b + cin, with cout as bit 32.
- R2: All ones plus 1 with cin = 0 gives sum = 0 and cout = 1. All ones plus all ones with cin = 1 gives sum = all ones and cout = 1.
- R3: Zero plus zero gives sum = 0 and cout = 0 when cin = 0, and sum = 1 and cout = 0 when cin = 1.
- R4: Sum bits 3..0 depend only on a[3:0], b[3:0] and cin. Changing any operand bit above bit 3 leaves them unchanged.
- R5: With slice widths 4, 4, 5, 6, 6 and 7 from the low end, slices begin at bits 0, 4, 8, 13, 19 and 25. A carry generated just below each of those boundaries appears in the sum or in cout as a + b + cin predicts.
- R6: A carry entering a slice whose bits all propagate passes through to the next slice. With a = all ones, b = 0 and cin = 1, the result is sum = 0 and cout = 1.
- R7: The alternating patterns 0x55555555 and 0xAAAAAAAA, in both operand orders and with both cin values, give a + b + cin.
- R8: The default slice widths sum to 32, so the ports are 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The bench builds the adder with its default slice widths of 4, 4, 5, 6, 6 and 7. These put the slice boundaries at bits 4, 8, 13, 19 and 25. With those boundaries fixed, the directed cases can place a generated carry exactly under each boundary, and they can drive a full-length propagate run across every select multiplexer. The random sweep then covers mixed generate and propagate patterns inside the wider 6- and 7-bit slices.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int MAX_BLK = 16;
  typedef logic [MAX_BLK*8-1:0] size_vec_t;

  function automatic int blk_w(size_vec_t s, int k);
    return int'(s[k*8 +: 8]);
  endfunction

  function automatic int blk_lo(size_vec_t s, int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += int'(s[i*8 +: 8]);
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  always_comb begin
    logic cr;
    cr = ci;
    for (int i = 0; i < W; i++) begin
      s[i] = a[i] ^ b[i] ^ cr;
      cr   = (a[i] & b[i]) | (cr & (a[i] ^ b[i]));
    end
    co = cr;
  end
endmodule

// File: rtl/csa_sel_block.sv
module csa_sel_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co,
  output logic [W-1:0] s_z,
  output logic [W-1:0] s_o,
  output logic         co_z,
  output logic         co_o
);
  csa_ripple #(.W(W)) u_zero (.a(a), .b(b), .ci(1'b0), .s(s_z), .co(co_z));
  csa_ripple #(.W(W)) u_one  (.a(a), .b(b), .ci(1'b1), .s(s_o), .co(co_o));

  assign s  = cin ? s_o : s_z;
  assign co = co_z | (co_o & cin);
endmodule

// File: rtl/csa_vblock_adder.sv
module csa_vblock_adder #(
  parameter int NBLK = 6,
  parameter logic [NBLK*8-1:0] BLK_SIZES = {8'd7, 8'd6, 8'd6, 8'd5, 8'd4, 8'd4},
  localparam csa_pkg::size_vec_t SZ = csa_pkg::size_vec_t'(BLK_SIZES),
  localparam int WIDTH = csa_pkg::blk_lo(SZ, NBLK)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [NBLK-1:0]  blk_cin;
  logic [NBLK-1:0]  blk_cout;
  logic [NBLK-1:0]  cand_co_z;
  logic [NBLK-1:0]  cand_co_o;
  logic [WIDTH-1:0] cand_s_z;
  logic [WIDTH-1:0] cand_s_o;

  assign blk_cin[0] = cin;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int LO = csa_pkg::blk_lo(SZ, k);
    localparam int W  = csa_pkg::blk_w(SZ, k);
    if (k == 0) begin : g_base
      csa_ripple #(.W(W)) u_rip (
        .a(a[LO +: W]), .b(b[LO +: W]), .ci(blk_cin[0]),
        .s(sum[LO +: W]), .co(blk_cout[0])
      );
      assign cand_s_z[LO +: W] = sum[LO +: W];
      assign cand_s_o[LO +: W] = sum[LO +: W];
      assign cand_co_z[0]      = blk_cout[0];
      assign cand_co_o[0]      = blk_cout[0];
    end else begin : g_sel
      assign blk_cin[k] = blk_cout[k-1];
      csa_sel_block #(.W(W)) u_sel (
        .a(a[LO +: W]), .b(b[LO +: W]), .cin(blk_cin[k]),
        .s(sum[LO +: W]), .co(blk_cout[k]),
        .s_z(cand_s_z[LO +: W]), .s_o(cand_s_o[LO +: W]),
        .co_z(cand_co_z[k]), .co_o(cand_co_o[k])
      );
    end
  end

  assign cout = blk_cout[NBLK-1];
endmodule

// File: rtl/csa_vblock_adder_chk.sv
module csa_vblock_adder_chk #(
  parameter int NBLK = 6,
  parameter logic [NBLK*8-1:0] BLK_SIZES = {8'd7, 8'd6, 8'd6, 8'd5, 8'd4, 8'd4},
  localparam csa_pkg::size_vec_t SZ = csa_pkg::size_vec_t'(BLK_SIZES),
  localparam int WIDTH = csa_pkg::blk_lo(SZ, NBLK)
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NBLK-1:0]  blk_cout,
  input logic [NBLK-1:0]  cand_co_z,
  input logic [NBLK-1:0]  cand_co_o
);
  localparam int W0 = csa_pkg::blk_w(SZ, 0);

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      logic [WIDTH:0] full;
      logic [W0:0]    low;
      full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      low  = {1'b0, a[W0-1:0]} + {1'b0, b[W0-1:0]} + {{W0{1'b0}}, cin};

      p_full_add_r1: assert ({cout, sum} == full)
        else $error("R1 result %h expected %h", {cout, sum}, full);
      p_low_block_r4: assert (sum[W0-1:0] == low[W0-1:0])
        else $error("R4 low slice %h expected %h", sum[W0-1:0], low[W0-1:0]);

      for (int k = 0; k < NBLK; k++) begin
        logic [WIDTH:0] m;
        logic [WIDTH:0] part;
        int hi;
        hi   = csa_pkg::blk_lo(SZ, k) + csa_pkg::blk_w(SZ, k) - 1;
        m    = {(WIDTH+1){1'b1}} >> (WIDTH - hi);
        part = ({1'b0, a} & m) + ({1'b0, b} & m) + {{WIDTH{1'b0}}, cin};
        p_blk_carry_r5: assert (blk_cout[k] == part[hi+1])
          else $error("R5 slice %0d carry %b expected %b", k, blk_cout[k], part[hi+1]);
        p_cand_order_r6: assert (!cand_co_z[k] || cand_co_o[k])
          else $error("R6 slice %0d zero-carry candidate set without one-carry candidate", k);
      end
    end
  end
endmodule

bind csa_vblock_adder csa_vblock_adder_chk #(.NBLK(NBLK), .BLK_SIZES(BLK_SIZES)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .blk_cout(blk_cout), .cand_co_z(cand_co_z), .cand_co_o(cand_co_o)
);

// File: tb/csa_vblock_adder_tb.sv
`timescale 1ns/1ps
module csa_vblock_adder_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a, b, sum;
  logic cin, cout;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csa_vblock_adder u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc);
    @(negedge clk);
    a = xa; b = xb; cin = xc;
    #1;
  endtask

  task automatic check_add(input string req);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%b got %h expected %h", req, a, b, cin, {cout, sum}, exp);
    end
  endtask

  task automatic check_val(input string req, input logic [W:0] exp);
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, {cout, sum}, exp);
    end
  endtask

  task automatic t_width_r8();
    n_chk++;
    if ($bits(u_dut.sum) != 32) begin
      n_bad++;
      $display("FAIL R8 width got %0d expected 32", $bits(u_dut.sum));
    end
  endtask

  task automatic t_zero_r3();
    apply('0, '0, 1'b0); check_val("R3", 33'h0);
    apply('0, '0, 1'b1); check_val("R3", 33'h1);
  endtask

  task automatic t_all_ones_r2();
    apply('1, 32'h1, 1'b0); check_val("R2", {1'b1, 32'h0});
    apply('1, '1, 1'b1);    check_val("R2", {1'b1, 32'hFFFF_FFFF});
  endtask

  task automatic t_low_isolation_r4();
    logic [3:0] ref_low;
    apply(32'h0000_0009, 32'h0000_0008, 1'b1);
    ref_low = sum[3:0];
    n_chk++;
    if (ref_low !== 4'h2) begin
      n_bad++;
      $display("FAIL R4 low nibble got %h expected 2", ref_low);
    end
    for (int i = 0; i < 8; i++) begin
      apply({$urandom} & 32'hFFFF_FFF0 | 32'h9, {$urandom} & 32'hFFFF_FFF0 | 32'h8, 1'b1);
      n_chk++;
      if (sum[3:0] !== 4'h2) begin
        n_bad++;
        $display("FAIL R4 low nibble got %h expected 2", sum[3:0]);
      end
    end
  endtask

  task automatic t_boundaries_r5();
    int bnd [6] = '{4, 8, 13, 19, 25, 32};
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] m;
      m = 32'hFFFF_FFFF >> (32 - bnd[i]);
      apply(m, 32'h1, 1'b0);        check_add("R5");
      apply(m, '0, 1'b1);           check_add("R5");
      apply(32'h1 << (bnd[i]-1), 32'h1 << (bnd[i]-1), 1'b0); check_add("R5");
    end
  endtask

  task automatic t_propagate_r6();
    apply('1, '0, 1'b1); check_val("R6", {1'b1, 32'h0});
    apply('0, '1, 1'b1); check_val("R6", {1'b1, 32'h0});
    apply('1, '0, 1'b0); check_val("R6", {1'b0, 32'hFFFF_FFFF});
  endtask

  task automatic t_alternating_r7();
    for (int c = 0; c < 2; c++) begin
      apply(32'h5555_5555, 32'hAAAA_AAAA, c[0]); check_add("R7");
      apply(32'hAAAA_AAAA, 32'h5555_5555, c[0]); check_add("R7");
      apply(32'h5555_5555, 32'h5555_5555, c[0]); check_add("R7");
      apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, c[0]); check_add("R7");
    end
  endtask

  task automatic t_random_r1();
    for (int i = 0; i < 10000; i++) begin
      apply($urandom, $urandom, 1'($urandom));
      check_add("R1");
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_val("R3 idle", 33'h0);
    t_width_r8();
    t_zero_r3();
    t_all_ones_r2();
    t_low_isolation_r4();
    t_boundaries_r5();
    t_propagate_r6();
    t_alternating_r7();
    t_random_r1();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule